// File: doc/BRIEF.md
# Multi-Rate Sample Bit Interleaver

This block sits behind a capture front end that can sample at one, two or four times the base rate. It gathers the samples that arrive in the fast domain and packs them into 16-bit storage words, one word per base-rate period. Word width stays fixed. The number of channels kept trades against the number of samples per word: 16 channels with one sample per word, 8 channels with two, or 4 channels with four.

Inside a word the sub-samples are bit-interleaved, not concatenated. Channel `c` of sub-sample `s` sits at bit `c*N + s`, where `N` is the number of samples per word. Sub-sample 0 is the earliest sample taken in the period.

A mode input selects the ratio. Each input sample carries a valid strobe. When a word completes, it is presented with a single-cycle valid pulse and then held until the next word completes. Changing the mode throws away any partly built word, so a word never mixes two modes.

Top module: `sample_interleaver`

## Requirements
- R1: With mode code 2'b00, or the spare code 2'b11, every accepted sample is emitted unchanged as a word. The word valid pulse comes one cycle after the sample's valid.
- R2: With mode code 2'b01 (two samples per word), bit `2*c + s` of the word equals channel `c` (sample bits 7:0) of sub-sample `s`, for `s` in 0..1.
- R3: With mode code 2'b10 (four samples per word), bit `4*c + s` of the word equals channel `c` (sample bits 3:0) of sub-sample `s`, for `s` in 0..3.
- R4: Sub-sample numbers follow the order in which valid samples arrive, starting at 0. Cycles without valid are skipped and do not consume a slot.
- R5: `word_vld_o` is high for exactly one cycle after every N-th accepted sample, in the cycle after that sample. It is never high in a cycle that does not follow an accepted sample.
- R6: Sample bits above the active channel count (bits 15:8 in 2x mode, bits 15:4 in 4x mode) have no effect on the word.
- R7: A change of the mode code discards any partly built word. A sample accepted in the cycle of the change becomes sub-sample 0 of the new mode.
- R8: While reset is asserted, `word_o` is zero and `word_vld_o` is low. After reset the next accepted sample is sub-sample 0 in 1x mode.
- R9: `word_o` holds the last completed word, unchanged, in every cycle without a word valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Ratio select: 00 = 1x, 01 = 2x, 10 = 4x, 11 = 1x |
| samp_i | input | 16 | Sample, one bit per channel |
| samp_vld_i | input | 1 | Sample valid strobe |
| word_o | output | 16 | Interleaved storage word |
| word_vld_o | output | 1 | Single-cycle pulse when a new word is presented |

## Verification
The interesting collision is a mode change in the same cycle as an accepted sample. That sample must both restart the word and become its first sub-sample. In 1x mode it must also complete a word at once. The bench provokes this with directed cases and with random mode changes placed on top of random valid traffic. The reference model replays the restart rule and checks the valid pulse and the packed word in the cycle that follows.

// File: rtl/sample_interleaver_pkg.sv
package sample_interleaver_pkg;
    localparam int DATA_W   = 16;
    localparam int LOG_MAXR = 2;              // up to 4 sub-samples per word
    localparam int SLOT_W   = LOG_MAXR;
    localparam int NVAR     = LOG_MAXR + 1;   // ratios 1, 2, 4

    typedef enum logic [1:0] {
        MODE_X1    = 2'b00,
        MODE_X2    = 2'b01,
        MODE_X4    = 2'b10,
        MODE_SPARE = 2'b11
    } mode_e;

    typedef struct packed {
        logic [SLOT_W-1:0] cnt;
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] word;
        logic              vld;
        logic [1:0]        mode;
    } state_t;
endpackage

// File: rtl/ilv_mode_dec.sv
module ilv_mode_dec
    import sample_interleaver_pkg::*;
#(
    parameter int SW = SLOT_W
) (
    input  logic [1:0]    mode,
    output logic [1:0]    ratio_log,
    output logic [SW-1:0] last_slot
);
    always_comb begin
        unique case (mode)
            MODE_X2: ratio_log = 2'd1;
            MODE_X4: ratio_log = 2'd2;
            default: ratio_log = 2'd0;
        endcase
        last_slot = SW'((1 << ratio_log) - 1);
    end
endmodule

// File: rtl/ilv_place.sv
module ilv_place
    import sample_interleaver_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int SW = SLOT_W,
    parameter int NV = NVAR
) (
    input  logic [W-1:0]  samp,
    input  logic [SW-1:0] slot,
    input  logic [1:0]    ratio_log,
    output logic [W-1:0]  bits,
    output logic [W-1:0]  mask
);
    logic [W-1:0] vb [NV];
    logic [W-1:0] vm [NV];

    for (genvar g = 0; g < NV; g++) begin : g_var
        localparam int R  = 1 << g;
        localparam int CH = W / R;
        logic [W-1:0] b_v, m_v;
        always_comb begin
            b_v = '0;
            m_v = '0;
            for (int c = 0; c < CH; c++) begin
                b_v[c*R + (int'(slot) % R)] = samp[c];
                m_v[c*R + (int'(slot) % R)] = 1'b1;
            end
        end
        assign vb[g] = b_v;
        assign vm[g] = m_v;
    end

    always_comb begin
        bits = vb[0];
        mask = vm[0];
        for (int g = 1; g < NV; g++) begin
            if (int'(ratio_log) == g) begin
                bits = vb[g];
                mask = vm[g];
            end
        end
    end
endmodule

// File: rtl/sample_interleaver.sv
module sample_interleaver
    import sample_interleaver_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic [DATA_W-1:0] samp_i,
    input  logic              samp_vld_i,
    output logic [DATA_W-1:0] word_o,
    output logic              word_vld_o
);
    state_t            st_q, st_d;
    logic [1:0]        ratio_log;
    logic [SLOT_W-1:0] last_slot;
    logic [SLOT_W-1:0] slot;
    logic              restart;
    logic [DATA_W-1:0] bits, mask, base, merged;

    ilv_mode_dec #(.SW(SLOT_W)) u_dec (
        .mode      (mode_i),
        .ratio_log (ratio_log),
        .last_slot (last_slot)
    );

    ilv_place #(.W(DATA_W), .SW(SLOT_W), .NV(NVAR)) u_place (
        .samp      (samp_i),
        .slot      (slot),
        .ratio_log (ratio_log),
        .bits      (bits),
        .mask      (mask)
    );

    assign restart = (mode_i != st_q.mode);
    assign slot    = restart ? '0 : st_q.cnt;
    assign base    = (slot == '0) ? '0 : st_q.acc;
    assign merged  = (base & ~mask) | bits;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.mode = mode_i;
        if (restart) begin
            st_d.cnt = '0;
            st_d.acc = '0;
        end
        if (samp_vld_i) begin
            st_d.acc = merged;
            if (slot == last_slot) begin
                st_d.cnt  = '0;
                st_d.word = merged;
                st_d.vld  = 1'b1;
            end else begin
                st_d.cnt = slot + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, acc: '0, word: '0, vld: 1'b0, mode: MODE_X1};
        end else begin
            st_q <= st_d;
        end
    end

    assign word_o     = st_q.word;
    assign word_vld_o = st_q.vld;
endmodule

// File: rtl/sample_interleaver_chk.sv
module sample_interleaver_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  mode_i,
    input logic [15:0] samp_i,
    input logic        samp_vld_i,
    input logic [15:0] word_o,
    input logic        word_vld_o
);
    // R5
    pulse_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld_o |-> $past(samp_vld_i));

    // R1
    x1_passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_o && ($past(mode_i) == 2'b00 || $past(mode_i) == 2'b11))
        |-> word_o == $past(samp_i));

    // R3
    x4_no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_vld_o && mode_i == 2'b10 && $past(mode_i) == 2'b10) |=> !word_vld_o);

    // R7
    restart_on_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != $past(mode_i) && (mode_i == 2'b01 || mode_i == 2'b10)) |=> !word_vld_o);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_vld_o |-> $stable(word_o));
endmodule

bind sample_interleaver sample_interleaver_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .samp_i     (samp_i),
    .samp_vld_i (samp_vld_i),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
);

// File: tb/sample_interleaver_test.sv
module sample_interleaver_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_i = 2'b00;
    logic [15:0] samp_i = '0;
    logic        samp_vld_i = 1'b0;
    logic [15:0] word_o;
    logic        word_vld_o;

    int checks = 0;
    int fails  = 0;

    logic [1:0]  m_prev = 2'b00;
    int          m_cnt = 0;
    logic [15:0] m_slot [4];
    logic [15:0] m_word = '0;
    logic        m_vld = 1'b0;

    always #5 clk = ~clk;

    sample_interleaver uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .samp_i(samp_i),
        .samp_vld_i(samp_vld_i), .word_o(word_o), .word_vld_o(word_vld_o)
    );

    function automatic int ratio(input logic [1:0] m);
        return (m == 2'b01) ? 2 : (m == 2'b10) ? 4 : 1;
    endfunction

    function automatic logic [15:0] pack(input int n);
        logic [15:0] w = '0;
        for (int s = 0; s < n; s++)
            for (int c = 0; c < 16 / n; c++)
                w[c*n + s] = m_slot[s][c];
        return w;
    endfunction

    task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle at negedge, update model, check at next negedge
    task automatic cyc(input logic [1:0] m, input logic v, input logic [15:0] d, input string req);
        mode_i = m; samp_vld_i = v; samp_i = d;
        if (m != m_prev) m_cnt = 0;
        m_prev = m;
        m_vld = 1'b0;
        if (v) begin
            m_slot[m_cnt] = d;
            m_cnt++;
            if (m_cnt == ratio(m)) begin
                m_word = pack(ratio(m));
                m_vld = 1'b1;
                m_cnt = 0;
            end
        end
        @(posedge clk); @(negedge clk);
        chk(word_vld_o == m_vld, {req, " valid (R5)"}, {15'd0, word_vld_o}, {15'd0, m_vld});
        chk(word_o == m_word, {req, " word (R9)"}, word_o, m_word);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(word_o == 16'h0 && !word_vld_o, "R8 reset", word_o, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(word_o == 16'h0 && !word_vld_o, "R8 after reset", word_o, 16'h0);

        // R1 passthrough and spare code
        cyc(2'b00, 1'b1, 16'hA5C3, "R1");
        cyc(2'b00, 1'b0, 16'h1111, "R4 idle");
        cyc(2'b11, 1'b1, 16'h7E81, "R1 spare");
        // R2: 0x00FF then 0 -> 0x5555
        cyc(2'b01, 1'b1, 16'h00FF, "R2");
        cyc(2'b01, 1'b0, 16'hFFFF, "R4 gap");
        cyc(2'b01, 1'b1, 16'h0000, "R2");
        chk(word_o == 16'h5555, "R2 direct", word_o, 16'h5555);
        // R6 upper bits ignored in 2x
        cyc(2'b01, 1'b1, 16'hFF00, "R6");
        cyc(2'b01, 1'b1, 16'hFF00, "R6");
        chk(word_o == 16'h0000, "R6 direct", word_o, 16'h0000);
        // R3: slot 3 all ones -> 0x8888
        cyc(2'b10, 1'b1, 16'hFFF0, "R3");
        cyc(2'b10, 1'b1, 16'h0000, "R3");
        cyc(2'b10, 1'b1, 16'h0000, "R3");
        cyc(2'b10, 1'b1, 16'h000F, "R3");
        chk(word_o == 16'h8888, "R3 direct", word_o, 16'h8888);
        // R7 change mid-word, sample in change cycle is slot 0
        cyc(2'b10, 1'b1, 16'h000F, "R7");
        cyc(2'b10, 1'b1, 16'h000F, "R7");
        cyc(2'b01, 1'b1, 16'h0001, "R7");
        cyc(2'b01, 1'b1, 16'h0000, "R7");
        chk(word_o == 16'h0001, "R7 direct", word_o, 16'h0001);
        cyc(2'b01, 1'b1, 16'h0003, "R7");
        cyc(2'b00, 1'b1, 16'hBEEF, "R7 to 1x");
        chk(word_o == 16'hBEEF, "R7 direct 1x", word_o, 16'hBEEF);

        // random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] m = mode_i;
            if ($urandom_range(0, 39) == 0) m = 2'($urandom_range(0, 3));
            cyc(m, ($urandom_range(0, 9) < 7), 16'($urandom), "R4 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule